// File: doc/BRIEF.md
# PHY Management Serial Master

This block lets a processor read and write the registers of an Ethernet PHY over the two-wire management interface. Software programs the target through a small 32-bit register window. The target is a PHY address, a register number and a read or write operation. For a write, software also sets the value to send. Software then launches the transfer by setting a status bit in the control register. The block builds a standard clause-22 frame and shifts it out on MDIO against a divided clock on MDC. It releases the MDIO driver for the turnaround and data phase of reads. The status bit stays set until the frame has finished.

The data pin is split into an output, an output enable and an input, so that the pad or an open-drain wrapper sits outside the block. Software polls the status bit. When it returns to 0, the captured read data can be fetched.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register offsets are fixed by software: target at 0x7E4, send value at 0x7E8, received value at 0x7EC, control at 0x7F0. The target register keeps bits [10:0]: register number in [4:0], PHY address in [9:5], operation in [10]. The send-value register keeps bits [15:0]. Unused bits read as 0.
- R2: After reset, all four registers read 0, MDC is low and the MDIO output enable is low.
- R3: Control bit 3 is the enable. It reads back the last value written. A control write whose bit 3 is 0 never starts a transfer.
- R4: Control bit 0 is the status bit. Writing it as 1 together with bit 3 as 1 while idle starts a transfer. It reads 1 for exactly 64·CLK_DIV clock cycles, then returns to 0.
- R5: A write frame is sent MSB first as 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10 and the 16-bit send value. The output enable is high for all 64 bits.
- R6: Target bit 10 set to 1 selects a read frame. A read frame carries opcode 10. The output enable is low from the first turnaround bit (bit 46 of the frame) to the end of the frame.
- R7: On a read, the 16 MDIO input bits of the data phase are captured MSB first. The received-value register keeps its old value until the frame completes, and then takes the captured data.
- R8: A start written while a transfer is in progress is ignored. Only one frame appears, and it carries the target that was latched at its launch.
- R9: MDC has a period of CLK_DIV clock cycles during a transfer and is low when idle. MDIO output and enable change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong frame shifter or bit counter shows up on the pins within one MDC period: a misplaced opcode, address or turnaround bit, or an enable that drops at the wrong bit. The scoreboard compares each whole frame bit by bit against one built from the requirements. Errors in the busy or capture logic show up at the register window. The status bit stays set too long or too briefly. The received value changes before completion, or holds wrongly ordered bits. A start that is wrongly accepted produces an extra frame. Each of these is seen at the first register read or frame boundary after the fault.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int CLK_DIV = 8,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [ADDR_W-1:0] OFS_TGT  = ADDR_W'('h7E4);
  localparam logic [ADDR_W-1:0] OFS_SEND = ADDR_W'('h7E8);
  localparam logic [ADDR_W-1:0] OFS_RECV = ADDR_W'('h7EC);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h7F0);

  logic [10:0]   tgt_q;
  logic [15:0]   send_q, rd_q, cap_q;
  logic          en_q, busy_q, op_rd_q;
  logic [CW-1:0] div_q;
  logic [5:0]    bit_q;
  logic [63:0]   sh_q;

  wire ctrl_wr   = bus_we && (bus_addr == OFS_CTRL);
  wire start     = ctrl_wr && bus_wdata[0] && bus_wdata[3] && !busy_q;
  wire fall_tick = busy_q && (div_q == CW'(CLK_DIV - 1));
  wire rise_tick = busy_q && (div_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      send_q  <= '0;
      rd_q    <= '0;
      cap_q   <= '0;
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      if (bus_we && bus_addr == OFS_TGT)  tgt_q  <= bus_wdata[10:0];
      if (bus_we && bus_addr == OFS_SEND) send_q <= bus_wdata[15:0];
      if (ctrl_wr)                        en_q   <= bus_wdata[3];
      if (start) begin
        busy_q  <= 1'b1;
        op_rd_q <= tgt_q[10];
        div_q   <= '0;
        bit_q   <= '0;
        sh_q    <= {32'hFFFF_FFFF, 2'b01, (tgt_q[10] ? 2'b10 : 2'b01),
                    tgt_q[9:5], tgt_q[4:0], 2'b10, send_q};
      end else if (busy_q) begin
        div_q <= fall_tick ? '0 : div_q + 1'b1;
        if (rise_tick && bit_q >= 6'd48) cap_q <= {cap_q[14:0], mdio_i};
        if (fall_tick) begin
          sh_q  <= {sh_q[62:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 6'd63) begin
            busy_q <= 1'b0;
            if (op_rd_q) rd_q <= cap_q;
          end
        end
      end
    end
  end

  assign mdc     = busy_q && (div_q >= CW'(HALF));
  assign mdio_oe = busy_q && !(op_rd_q && bit_q >= 6'd46);
  assign mdio_o  = mdio_oe && sh_q[63];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_TGT:  bus_rdata = {21'b0, tgt_q};
      OFS_SEND: bus_rdata = {16'b0, send_q};
      OFS_RECV: bus_rdata = {16'b0, rd_q};
      OFS_CTRL: bus_rdata = {28'b0, en_q, 2'b00, busy_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy_q,
  input logic        en_q,
  input logic [5:0]  bit_q,
  input logic [15:0] rd_q
);
  // R9
  mdio_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R6
  oe_rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $rose(busy_q));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (bit_q >= $past(bit_q)));
  // R4
  done_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(bit_q) == 6'd63));
  // R3
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> en_q);
  // R7
  recv_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_q) |-> $fell(busy_q));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy_q(busy_q), .en_q(en_q), .bit_q(bit_q), .rd_q(rd_q)
);

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  localparam int DIV = 8;
  localparam logic [11:0] A_TGT = 12'h7E4, A_SEND = 12'h7E8,
                          A_RECV = 12'h7EC, A_CTRL = 12'h7F0;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, mdio_i = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe;

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.CLK_DIV(DIV), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  int n_chk = 0, n_fail = 0, frames = 0, nbits = 0;
  logic [63:0] exp_f_q[$], exp_oe_q[$];
  logic [63:0] obs_f = '0, obs_oe = '0;
  logic [15:0] phy_resp = '0;
  logic period_done = 1'b0;
  realtime t_first = 0.0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f, oe;
    f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    oe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    exp_f_q.push_back(f & oe);
    exp_oe_q.push_back(oe);
  endtask

  // monitor: pop and compare each frame
  always @(posedge mdc) begin
    obs_f  = {obs_f[62:0], mdio_oe ? mdio_o : 1'b0};
    obs_oe = {obs_oe[62:0], mdio_oe};
    nbits++;
    if (nbits == 1) t_first = $realtime;
    if (nbits == 2 && !period_done) begin
      period_done = 1'b1;
      chk(($realtime - t_first) == DIV * 5.0, "R9 mdc period",
          64'($rtoi($realtime - t_first)), 64'(DIV * 5));
    end
    if (nbits == 64) begin
      frames++;
      nbits = 0;
      if (exp_f_q.size() == 0) chk(1'b0, "R8 unexpected frame", obs_f, 64'h0);
      else begin
        logic [63:0] ef, eo;
        ef = exp_f_q.pop_front();
        eo = exp_oe_q.pop_front();
        chk(obs_f == ef, eo[0] ? "R5 write frame" : "R6 read frame", obs_f, ef);
        chk(obs_oe == eo, eo[0] ? "R5 write enable" : "R6 read enable release", obs_oe, eo);
      end
    end
  end

  // PHY model: drive data bits after falling edge
  always @(negedge mdc) begin
    if (nbits >= 48 && nbits < 64) mdio_i = phy_resp[63 - nbits];
    else mdio_i = 1'b1;
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 100000; i++) begin
      bus_rd(A_CTRL, v);
      if (!v[0]) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    bus_rd(A_TGT, v);  chk(v == 0, "R2 target reset", 64'(v), 64'h0);
    bus_rd(A_SEND, v); chk(v == 0, "R2 send reset", 64'(v), 64'h0);
    bus_rd(A_RECV, v); chk(v == 0, "R2 recv reset", 64'(v), 64'h0);
    bus_rd(A_CTRL, v); chk(v == 0, "R2 ctrl reset", 64'(v), 64'h0);
    chk(!mdc && !mdio_oe, "R2 pins idle", {62'b0, mdc, mdio_oe}, 64'h0);

    // R1 field widths and readback
    bus_wr(A_TGT, 32'hFFFF_FFFF);  bus_rd(A_TGT, v);  chk(v == 32'h7FF, "R1 target bits", 64'(v), 64'h7FF);
    bus_wr(A_SEND, 32'h1234_BEEF); bus_rd(A_SEND, v); chk(v == 32'hBEEF, "R1 send bits", 64'(v), 64'hBEEF);

    // R3 start with enable clear is ignored
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_CTRL, v); chk(v == 0, "R3 disabled start", 64'(v), 64'h0);
    repeat (200) @(negedge clk);
    chk(frames == 0 && nbits == 0 && !mdc, "R3 no frame while disabled", 64'(frames), 64'h0);
    bus_wr(A_CTRL, 32'h8);
    bus_rd(A_CTRL, v); chk(v == 32'h8, "R3 enable readback", 64'(v), 64'h8);

    // R5 write frame, R4 duration
    bus_wr(A_TGT, 32'h071);
    bus_wr(A_SEND, 32'hC35A);
    push_frame(1'b0, 5'd3, 5'd17, 16'hC35A);
    bus_wr(A_CTRL, 32'h9);
    wait_idle(n);
    chk(n == 64 * DIV, "R4 busy duration", 64'(n), 64'(64 * DIV));
    bus_rd(A_CTRL, v); chk(v == 32'h8, "R4 status cleared", 64'(v), 64'h8);

    // R6/R7 read, R8 start while busy
    phy_resp = 16'hA5C3;
    bus_wr(A_TGT, 32'h400 | (31 << 5) | 2);
    push_frame(1'b1, 5'd31, 5'd2, 16'h0);
    bus_wr(A_CTRL, 32'h9);
    repeat (100) @(negedge clk);
    bus_rd(A_RECV, v); chk(v == 0, "R7 recv held mid-frame", 64'(v), 64'h0);
    bus_wr(A_TGT, 32'h0A5);
    bus_wr(A_CTRL, 32'h9);
    wait_idle(n);
    bus_rd(A_RECV, v); chk(v == 32'hA5C3, "R7 recv captured", 64'(v), 64'hA5C3);
    f0 = frames;
    repeat (64 * DIV + 100) @(negedge clk);
    chk(frames == f0 && exp_f_q.size() == 0, "R8 ignored start", 64'(frames), 64'(f0));

    // second read: MSB/LSB corner
    phy_resp = 16'h8001;
    bus_wr(A_TGT, 32'h400);
    push_frame(1'b1, 5'd0, 5'd0, 16'h0);
    bus_wr(A_CTRL, 32'h9);
    repeat (300) @(negedge clk);
    bus_rd(A_RECV, v); chk(v == 32'hA5C3, "R7 old value held", 64'(v), 64'hA5C3);
    wait_idle(n);
    bus_rd(A_RECV, v); chk(v == 32'h8001, "R7 recv msb first", 64'(v), 64'h8001);

    // write with all-ones address fields and zero data
    bus_wr(A_TGT, 32'h3FF);
    bus_wr(A_SEND, 32'h0);
    push_frame(1'b0, 5'd31, 5'd31, 16'h0);
    bus_wr(A_CTRL, 32'h9);
    wait_idle(n);
    repeat (20) @(negedge clk);
    chk(exp_f_q.size() == 0 && frames == 4, "R5 all frames seen", 64'(frames), 64'h4);
    chk(!mdc && !mdio_oe, "R9 idle mdc low", {62'b0, mdc, mdio_oe}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule